// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block routes a parameterised set of external interrupt request lines to the processors of a small multiprocessor system. Each input has its own two-word redirection entry. The entry sets whether the input is masked, whether it triggers on edges or on levels, its polarity, the 8-bit vector it delivers, the destination identifier and the destination mode. When an input becomes eligible, the block issues one delivery message on a valid/ready handshake. Level-triggered inputs wait for an end-of-interrupt strobe that names their vector before they are sent again.

Software reaches the block through a two-location indirect window. A write at byte offset 0x00 selects an internal register. Reads and writes at byte offset 0x10 then act on the selected register. The internal registers are an identification register, a version register and the redirection table.

Top module: `irq_router`

## Requirements
- R1: A write at offset 0x00 loads the 8-bit register index, and a read at offset 0x00 returns that index in bits 7:0. Reads and writes at offset 0x10 act on the selected register. Writes at any other offset change nothing, and reads there return zero.
- R2: Index 0x00 is the identification register, with a writable identifier in bits 31:24. Index 0x01 is the version register, which reads NUM_IRQ-1 in bits 23:16 and ignores writes. All other bits of both registers read as zero.
- R3: For input n, the low word is at index 0x10+2n. In it, bit 16 masks the input, bit 15 selects level trigger, bit 13 selects active-low polarity, bit 11 selects logical destination mode, and bits 7:0 hold the vector. The high word is at index 0x11+2n and holds the destination in bits 31:24. Every other bit reads as zero.
- R4: After reset, every low word reads 0x00010000 (masked, edge-triggered, active-high, vector 0), every high word reads 0, the identifier is 0 and msg_valid is low.
- R5: In edge mode, a transition of an unmasked input into its asserted level produces exactly one message. That message carries the entry's vector, its destination and its mode bit. A steady level after the transition produces nothing more.
- R6: With active-low polarity, a falling edge on the input triggers the message in edge mode.
- R7: A masked input never latches a pending request, so clearing the mask afterwards sends no message for the earlier edge.
- R8: A level-mode input that is asserted is sent once. It is not sent again until an end-of-interrupt strobe carries its vector. A strobe with any other vector has no effect.
- R9: When several inputs are eligible at the same time, the message for the lowest-numbered input goes first.
- R10: While msg_valid is high and msg_ready is low, msg_valid, msg_vector, msg_dest and msg_logical stay stable.
- R11: An index that selects no implemented register reads zero through the data location, and writes to it are ignored.
- R12: In the cycle after a message is accepted, msg_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | 5 | Byte offset within the window (0x00 index, 0x10 data) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr and state |
| irq_in | input | NUM_IRQ | Interrupt request lines |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector named by the end-of-interrupt strobe |
| msg_valid | output | 1 | Delivery message valid |
| msg_ready | input | 1 | Delivery message accepted when high with msg_valid |
| msg_vector | output | 8 | Vector of the delivered interrupt |
| msg_dest | output | 8 | Destination identifier |
| msg_logical | output | 1 | Destination mode, 1 for logical |

## Verification
Register reads are combinational, so the bench samples bus_rdata at the falling edge right after the rising edge that wrote the index. An edge-mode input that changes at a falling edge latches its pending bit on the next rising edge, and msg_valid appears on the rising edge after that. A level-mode input, and a level-mode input released by a matching end-of-interrupt strobe, is launched one rising edge after it becomes eligible. Each message check therefore waits at least two full cycles after the stimulus, and holds msg_ready low until the payload has been compared. The gap after acceptance is checked at the first falling edge after the accepting rising edge.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int         NUM_IRQ  = 8,
  parameter logic [7:0] ID_RESET = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [4:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               eoi_valid,
  input  logic [7:0]         eoi_vector,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [7:0]         msg_vector,
  output logic [7:0]         msg_dest,
  output logic               msg_logical
);
  localparam int TBL_BASE = 16;
  localparam int TBL_END  = TBL_BASE + 2 * NUM_IRQ;
  localparam int SELW     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [7:0] VERSION = 8'(NUM_IRQ - 1);

  logic [7:0]         index_q, id_q;
  logic [NUM_IRQ-1:0] mask_q, level_q, actlow_q, logical_q;
  logic [NUM_IRQ-1:0] act_prev_q, pend_q, insvc_q;
  logic [7:0]         vec_q  [NUM_IRQ];
  logic [7:0]         dest_q [NUM_IRQ];

  logic              out_valid_q, out_logical_q;
  logic [7:0]        out_vec_q, out_dest_q;
  logic [SELW-1:0]   out_idx_q;

  wire sel_index = (bus_addr == 5'h00);
  wire sel_data  = (bus_addr == 5'h10);
  wire in_tbl    = (int'(index_q) >= TBL_BASE) && (int'(index_q) < TBL_END);
  wire [7:0]      tbl_off = index_q - 8'(TBL_BASE);
  wire [SELW-1:0] entry   = tbl_off[SELW:1];
  wire            hi_word = tbl_off[0];
  wire            wr_tbl  = bus_wr && sel_data && in_tbl;
  wire            accept  = out_valid_q && msg_ready;

  wire [NUM_IRQ-1:0] act  = irq_in ^ actlow_q;
  wire [NUM_IRQ-1:0] elig = ~mask_q & ((~level_q & pend_q) | (level_q & act & ~insvc_q));

  logic [SELW-1:0] pick;
  always_comb begin
    pick = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--)
      if (elig[i]) pick = SELW'(i);
  end

  logic [31:0] data_rd;
  always_comb begin
    data_rd = '0;
    if (index_q == 8'h00)      data_rd = {id_q, 24'h0};
    else if (index_q == 8'h01) data_rd = {8'h0, VERSION, 16'h0};
    else if (in_tbl) begin
      if (hi_word) data_rd = {dest_q[entry], 24'h0};
      else         data_rd = {15'h0, mask_q[entry], level_q[entry], 1'b0, actlow_q[entry],
                              1'b0, logical_q[entry], 3'h0, vec_q[entry]};
    end
  end

  assign bus_rdata = sel_index ? {24'h0, index_q} : (sel_data ? data_rd : 32'h0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= '0;  id_q <= ID_RESET;
      mask_q <= '1;   level_q <= '0;  actlow_q <= '0;  logical_q <= '0;
      act_prev_q <= '0;  pend_q <= '0;  insvc_q <= '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
        vec_q[i] <= '0;  dest_q[i] <= '0;
      end
      out_valid_q <= 1'b0;  out_idx_q <= '0;  out_vec_q <= '0;
      out_dest_q <= '0;     out_logical_q <= 1'b0;
    end else begin
      if (bus_wr && sel_index) index_q <= bus_wdata[7:0];
      if (bus_wr && sel_data && index_q == 8'h00) id_q <= bus_wdata[31:24];
      act_prev_q <= act;
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (wr_tbl && entry == SELW'(i)) begin
          if (hi_word) dest_q[i] <= bus_wdata[31:24];
          else begin
            mask_q[i]    <= bus_wdata[16];
            level_q[i]   <= bus_wdata[15];
            actlow_q[i]  <= bus_wdata[13];
            logical_q[i] <= bus_wdata[11];
            vec_q[i]     <= bus_wdata[7:0];
          end
        end
        if (accept && out_idx_q == SELW'(i))
          pend_q[i] <= 1'b0;
        else if (!mask_q[i] && !level_q[i] && act[i] && !act_prev_q[i])
          pend_q[i] <= 1'b1;
        if (accept && out_idx_q == SELW'(i) && level_q[i])
          insvc_q[i] <= 1'b1;
        else if (eoi_valid && eoi_vector == vec_q[i])
          insvc_q[i] <= 1'b0;
      end
      if (accept) out_valid_q <= 1'b0;
      else if (!out_valid_q && |elig) begin
        out_valid_q   <= 1'b1;
        out_idx_q     <= pick;
        out_vec_q     <= vec_q[pick];
        out_dest_q    <= dest_q[pick];
        out_logical_q <= logical_q[pick];
      end
    end
  end

  assign msg_valid   = out_valid_q;
  assign msg_vector  = out_vec_q;
  assign msg_dest    = out_dest_q;
  assign msg_logical = out_logical_q;

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dest) && $stable(msg_logical));

  assert_gap_after_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid);

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_chk
    assert_masked_no_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[g]) |-> $past(!mask_q[g]));
    assert_eoi_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(insvc_q[g]) |-> $past(eoi_valid && eoi_vector == vec_q[g]));
  end
endmodule

// File: tb/test_irq_router.sv
module test_irq_router;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq_in = '0;
  logic eoi_valid = 1'b0;
  logic [7:0] eoi_vector = '0;
  logic msg_valid, msg_ready = 1'b0, msg_logical;
  logic [7:0] msg_vector, msg_dest;
  int checks = 0, errors = 0;
  logic [31:0] r;

  always #2 clk = ~clk;

  irq_router #(.NUM_IRQ(N)) i_irq_router (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dest(msg_dest),
    .msg_logical(msg_logical));

  // {index, write data, expected readback}
  localparam logic [71:0] VEC [8] = '{
    {8'h00, 32'hAB123456, 32'hAB000000},
    {8'h01, 32'hFFFFFFFF, 32'h00070000},
    {8'h10, 32'hFFFFFFFF, 32'h0001A8FF},
    {8'h11, 32'h12345678, 32'h12000000},
    {8'h1E, 32'h00012000, 32'h00012000},
    {8'h1F, 32'hFFFFFFFF, 32'hFF000000},
    {8'h05, 32'hFFFFFFFF, 32'h00000000},
    {8'h20, 32'hFFFFFFFF, 32'h00000000}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
    bus_write(5'h00, {24'h0, idx});
    bus_write(5'h10, d);
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [31:0] d);
    bus_write(5'h00, {24'h0, idx});
    bus_addr = 5'h10; #1 d = bus_rdata;
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic accept_msg();
    @(negedge clk); msg_ready = 1'b1;
    @(negedge clk); msg_ready = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cycles(3); rst_n = 1'b1; cycles(1);
    // R4 reset state
    check("R4 valid", {31'h0, msg_valid}, 32'h0);
    reg_read(8'h12, r); check("R4 low word", r, 32'h00010000);
    reg_read(8'h13, r); check("R4 high word", r, 32'h0);
    reg_read(8'h00, r); check("R4 id", r, 32'h0);
    reg_read(8'h01, r); check("R2 version", r, 32'h00070000);

    // R1 R2 R3 R11 table walk
    for (int i = 0; i < 8; i++) begin
      reg_write(VEC[i][71:64], VEC[i][63:32]);
      reg_read(VEC[i][71:64], r);
      check("R1/R2/R3/R11 readback", r, VEC[i][31:0]);
    end

    // R1 index readback and write at other offset ignored
    bus_write(5'h00, 32'h00000013);
    bus_write(5'h08, 32'h00000055);
    bus_addr = 5'h00; #1 check("R1 index readback", bus_rdata, 32'h00000013);
    bus_addr = 5'h04; #1 check("R1 other offset reads 0", bus_rdata, 32'h0);

    // R5 edge, active-high
    reg_write(8'h14, 32'h00000042);
    reg_write(8'h15, 32'h03000000);
    @(negedge clk); irq_in[2] = 1'b1;
    cycles(3);
    check("R5 valid", {31'h0, msg_valid}, 32'h1);
    check("R5 vector", {24'h0, msg_vector}, 32'h42);
    check("R5 dest", {24'h0, msg_dest}, 32'h03);
    check("R5 mode", {31'h0, msg_logical}, 32'h0);
    cycles(3);
    check("R10 hold", {23'h0, msg_valid, msg_vector}, 32'h142);
    accept_msg();
    check("R12 gap", {31'h0, msg_valid}, 32'h0);
    cycles(4);
    check("R5 single message", {31'h0, msg_valid}, 32'h0);
    irq_in[2] = 1'b0;

    // R6 active-low edge, logical mode
    irq_in[3] = 1'b1;
    reg_write(8'h16, 32'h00002843);
    cycles(3);
    check("R6 idle while high", {31'h0, msg_valid}, 32'h0);
    irq_in[3] = 1'b0;
    cycles(3);
    check("R6 falling edge", {23'h0, msg_valid, msg_vector}, 32'h143);
    check("R3 logical mode", {31'h0, msg_logical}, 32'h1);
    accept_msg();

    // R7 masked input
    reg_write(8'h18, 32'h00010044);
    @(negedge clk); irq_in[4] = 1'b1;
    cycles(2); irq_in[4] = 1'b0;
    reg_write(8'h18, 32'h00000044);
    cycles(4);
    check("R7 no message after unmask", {31'h0, msg_valid}, 32'h0);

    // R9 priority
    reg_write(8'h1A, 32'h00000055);
    reg_write(8'h1C, 32'h00000066);
    @(negedge clk); irq_in[6] = 1'b1; irq_in[5] = 1'b1;
    cycles(3);
    check("R9 lowest first", {23'h0, msg_valid, msg_vector}, 32'h155);
    accept_msg();
    cycles(2);
    check("R9 next", {23'h0, msg_valid, msg_vector}, 32'h166);
    accept_msg();
    irq_in[6] = 1'b0; irq_in[5] = 1'b0;

    // R8 level mode
    reg_write(8'h12, 32'h00008031);
    reg_write(8'h13, 32'h07000000);
    @(negedge clk); irq_in[1] = 1'b1;
    cycles(3);
    check("R8 level sent", {15'h0, msg_valid, msg_dest, msg_vector}, 32'h10731);
    accept_msg();
    cycles(4);
    check("R8 not resent", {31'h0, msg_valid}, 32'h0);
    eoi(8'h99);
    cycles(3);
    check("R8 other vector", {31'h0, msg_valid}, 32'h0);
    eoi(8'h31);
    cycles(2);
    check("R8 resent after eoi", {23'h0, msg_valid, msg_vector}, 32'h131);
    accept_msg();
    irq_in[1] = 1'b0;
    eoi(8'h31);
    cycles(4);
    check("R8 idle when deasserted", {31'h0, msg_valid}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule